// File: doc/BRIEF.md
# Sub-word Load/Store Alignment Unit

This unit sits between a 32-bit register file and a 64-bit little-endian data memory port. For a load, it picks a byte, halfword or word out of the returned memory beat and widens it to 32 bits. A request flag selects signed or unsigned widening. For a store, it moves register data into the correct byte lanes and drives one byte enable per lane. A store variant can clamp a 32-bit value to the signed or unsigned range of a byte or halfword before the write.

The legal alignment depends on the register class. Transfers for address registers are always whole words and need a word-aligned address. Transfers for data registers need halfword alignment for halfwords and words, and bytes may sit at any address. A data-register word at lane offset 6 crosses into the next beat. The unit issues both beats back to back, raises `busy_o` while the second beat is out, and joins the two halves of a load. A misaligned request never reaches memory. It produces a one-cycle fault pulse that carries the request address.

Top module: `lsu_align`

## Requirements
- R1: Memory beats are 8-byte aligned (`mem_addr_o[2:0]` = 0), and the byte at address A sits in lane A mod 8, bits 8*(A mod 8)+7 down to 8*(A mod 8). Read data on `mem_rdata_i` is valid in the cycle after a read beat is requested. A single-beat load shows `ld_valid_o` and `ld_data_o` in the cycle after the request.
- R2: `req_size_i` encodes 0 = byte, 1 = halfword, and 2 or 3 = word. Byte and halfword loads are sign-extended when `req_signed_i` = 1 and zero-extended when it is 0.
- R3: When `req_areg_i` = 0, halfword and word accesses need `req_addr_i[0]` = 0, and byte accesses are legal at any address.
- R4: When `req_areg_i` = 1, the access is a word whatever `req_size_i` says. It needs `req_addr_i[1:0]` = 0, and the load result is not extended.
- R5: A misaligned request drives no memory request. In the next cycle `fault_o` is high for one cycle and `fault_addr_o` equals the request address.
- R6: A store drives `mem_we_o` and sets `mem_be_o` bits only for the lanes it writes. Each written lane carries the matching byte of the (possibly clamped) data, least significant byte at the lowest address.
- R7: A word access at lane offset 6 uses two beats. The first beat is at the base address with lanes 6 and 7, and the second, in the next cycle, is at base+8 with lanes 0 and 1. `busy_o` is high in the second cycle. A split load returns its joined result two cycles after the request.
- R8: A store with `req_sat_i` = 1 clamps a byte to [-128,127] (signed) or [0,255] (unsigned, value read as unsigned), and a halfword to [-32768,32767] or [0,65535]. Word stores are never clamped, and a store without the flag keeps only the low bytes.
- R9: While `rst_ni` is low, `busy_o`, `ld_valid_o` and `fault_o` are low, and so is `mem_req_o` when no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; ignored while busy_o is high |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_areg_i | input | 1 | 1 = address-register class |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed_i | input | 1 | Signed widening on load, signed clamp on store |
| req_sat_i | input | 1 | Clamp store data to the access width |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data |
| busy_o | output | 1 | Second beat of a split access in progress |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat address, 8-byte aligned |
| mem_be_o | output | 8 | Lane write enables |
| mem_wdata_o | output | 64 | Beat write data |
| mem_rdata_i | input | 64 | Beat read data, one cycle after the request |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Widened load result |
| fault_o | output | 1 | Alignment fault pulse |
| fault_addr_o | output | 32 | Address of the faulting request |

## Verification
A load result can come back in the same cycle that a new misaligned request must be held off the memory port. So the widened data path and the fault suppression work at the same edge. The bench provokes this by sending a misaligned request in the cycle right after a load. In that cycle it checks that `ld_valid_o` carries the model's value while `mem_req_o` stays low. It then checks that the fault pulse appears one cycle later, and every cycle the outputs are compared against a byte-level reference memory.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_align_pkg::*;
(
  input  logic       areg_i,
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lo_i,
  output logic [1:0] size_o,
  output logic [2:0] nbytes_o,
  output logic       misalign_o
);
  always_comb begin
    if (areg_i || size_i == SZ_WALT) size_o = SZ_WORD;
    else                             size_o = size_i;
    case (size_o)
      SZ_BYTE: nbytes_o = 3'd1;
      SZ_HALF: nbytes_o = 3'd2;
      default: nbytes_o = 3'd4;
    endcase
    if (areg_i) misalign_o = (addr_lo_i != 2'b00);
    else        misalign_o = (size_o != SZ_BYTE) && addr_lo_i[0];
  end
endmodule

// File: rtl/lsu_align_store.sv
module lsu_align_store
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BEAT_W = 64,
  localparam int LANES = BEAT_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic              sat_i,
  input  logic              sgn_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [BEAT_W-1:0] wd0_o,
  output logic [BEAT_W-1:0] wd1_o,
  output logic [LANES-1:0]  be0_o,
  output logic [LANES-1:0]  be1_o
);
  localparam logic signed [DATA_W-1:0] SB_MAX = DATA_W'(127);
  localparam logic signed [DATA_W-1:0] SB_MIN = -DATA_W'(128);
  localparam logic signed [DATA_W-1:0] SH_MAX = DATA_W'(32767);
  localparam logic signed [DATA_W-1:0] SH_MIN = -DATA_W'(32768);
  localparam logic [DATA_W-1:0]        UB_MAX = DATA_W'(255);
  localparam logic [DATA_W-1:0]        UH_MAX = DATA_W'(65535);

  logic [DATA_W-1:0]    clamped, narrow;
  logic [3:0]           mask;
  logic [2*BEAT_W-1:0]  wide;
  logic [2*LANES-1:0]   wide_be;

  always_comb begin
    clamped = data_i;
    if (sat_i) begin
      case (size_i)
        SZ_BYTE: begin
          if (sgn_i) begin
            if ($signed(data_i) > SB_MAX)      clamped = SB_MAX;
            else if ($signed(data_i) < SB_MIN) clamped = SB_MIN;
          end else if (data_i > UB_MAX)        clamped = UB_MAX;
        end
        SZ_HALF: begin
          if (sgn_i) begin
            if ($signed(data_i) > SH_MAX)      clamped = SH_MAX;
            else if ($signed(data_i) < SH_MIN) clamped = SH_MIN;
          end else if (data_i > UH_MAX)        clamped = UH_MAX;
        end
        default: clamped = data_i;
      endcase
    end
    case (size_i)
      SZ_BYTE: begin narrow = DATA_W'(clamped[7:0]);  mask = 4'b0001; end
      SZ_HALF: begin narrow = DATA_W'(clamped[15:0]); mask = 4'b0011; end
      default: begin narrow = clamped;                mask = 4'b1111; end
    endcase
    wide    = (2*BEAT_W)'(narrow) << {off_i, 3'b000};
    wide_be = (2*LANES)'(mask) << off_i;
  end

  assign wd0_o = wide[BEAT_W-1:0];
  assign wd1_o = wide[2*BEAT_W-1:BEAT_W];
  assign be0_o = wide_be[LANES-1:0];
  assign be1_o = wide_be[2*LANES-1:LANES];
endmodule

// File: rtl/lsu_align_load.sv
module lsu_align_load
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BEAT_W = 64,
  localparam int LANES = BEAT_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [2*BEAT_W-1:0] beats_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [1:0]          size_i,
  input  logic                sgn_i,
  output logic [DATA_W-1:0]   data_o
);
  logic [DATA_W-1:0] raw;
  always_comb begin
    raw = DATA_W'(beats_i >> {off_i, 3'b000});
    case (size_i)
      SZ_BYTE: data_o = sgn_i ? {{(DATA_W-8){raw[7]}}, raw[7:0]}
                              : {{(DATA_W-8){1'b0}}, raw[7:0]};
      SZ_HALF: data_o = sgn_i ? {{(DATA_W-16){raw[15]}}, raw[15:0]}
                              : {{(DATA_W-16){1'b0}}, raw[15:0]};
      default: data_o = raw;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 64,
  localparam int LANES = BEAT_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic              req_areg_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic              req_sat_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [BEAT_W-1:0] mem_wdata_o,
  input  logic [BEAT_W-1:0] mem_rdata_i,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] base;
  logic [1:0]        eff_size;
  logic [2:0]        nbytes;
  logic              misalign, accept, go, split;
  logic [BEAT_W-1:0] wd0, wd1;
  logic [LANES-1:0]  be0, be1;

  assign off  = req_addr_i[OFF_W-1:0];
  assign base = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  lsu_align_check i_check (
    .areg_i    (req_areg_i),
    .size_i    (req_size_i),
    .addr_lo_i (req_addr_i[1:0]),
    .size_o    (eff_size),
    .nbytes_o  (nbytes),
    .misalign_o(misalign)
  );

  lsu_align_store #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) i_store (
    .data_i(req_wdata_i),
    .size_i(eff_size),
    .sat_i (req_sat_i),
    .sgn_i (req_signed_i),
    .off_i (off),
    .wd0_o (wd0),
    .wd1_o (wd1),
    .be0_o (be0),
    .be1_o (be1)
  );

  logic busy_q;
  assign accept = req_valid_i && !busy_q;
  assign go     = accept && !misalign;
  assign split  = (int'(off) + int'(nbytes)) > LANES;

  // second-beat context
  logic              sb_we_q;
  logic [ADDR_W-1:0] sb_addr_q;
  logic [LANES-1:0]  sb_be_q;
  logic [BEAT_W-1:0] sb_wd_q;
  // load return context
  logic              rd_q, rd_last_q, split_q, sgn_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic [BEAT_W-1:0] lo_q;
  logic              fault_q;
  logic [ADDR_W-1:0] fault_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      sb_we_q      <= 1'b0;
      sb_addr_q    <= '0;
      sb_be_q      <= '0;
      sb_wd_q      <= '0;
      rd_q         <= 1'b0;
      rd_last_q    <= 1'b0;
      split_q      <= 1'b0;
      sgn_q        <= 1'b0;
      off_q        <= '0;
      size_q       <= SZ_BYTE;
      lo_q         <= '0;
      fault_q      <= 1'b0;
      fault_addr_q <= '0;
    end else begin
      busy_q    <= go && split;
      rd_q      <= (go && !req_store_i) || (busy_q && !sb_we_q);
      rd_last_q <= busy_q || !split;
      fault_q   <= accept && misalign;
      if (accept && misalign) fault_addr_q <= req_addr_i;
      if (go) begin
        sb_we_q   <= req_store_i;
        sb_addr_q <= base + ADDR_W'(LANES);
        sb_be_q   <= be1;
        sb_wd_q   <= wd1;
        split_q   <= split;
        sgn_q     <= req_signed_i && !req_areg_i;
        off_q     <= off;
        size_q    <= eff_size;
      end
      if (rd_q && !rd_last_q) lo_q <= mem_rdata_i;
    end
  end

  always_comb begin
    if (busy_q) begin
      mem_req_o   = 1'b1;
      mem_we_o    = sb_we_q;
      mem_addr_o  = sb_addr_q;
      mem_be_o    = sb_we_q ? sb_be_q : '0;
      mem_wdata_o = sb_wd_q;
    end else begin
      mem_req_o   = go;
      mem_we_o    = go && req_store_i;
      mem_addr_o  = base;
      mem_be_o    = (go && req_store_i) ? be0 : '0;
      mem_wdata_o = wd0;
    end
  end

  lsu_align_load #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) i_load (
    .beats_i(split_q ? {mem_rdata_i, lo_q} : {{BEAT_W{1'b0}}, mem_rdata_i}),
    .off_i  (off_q),
    .size_i (size_q),
    .sgn_i  (sgn_q),
    .data_o (ld_data_o)
  );

  assign busy_o       = busy_q;
  assign ld_valid_o   = rd_q && rd_last_q;
  assign fault_o      = fault_q;
  assign fault_addr_o = fault_addr_q;

  AST_BEAT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[OFF_W-1:0] == '0); // R1
  AST_LOAD_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> $past(mem_req_o && !mem_we_o)); // R1
  AST_FAULT_SUPPRESSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(!mem_req_o)); // R5
  AST_STORE_HAS_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_be_o != '0); // R6
  AST_SECOND_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> mem_req_o && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(LANES))); // R7
  AST_NO_FAULT_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !fault_o); // R7
endmodule

// File: tb/test_lsu_align.sv
`timescale 1ns/1ps
module test_lsu_align;
  localparam time TCK = 5ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 0, req_store_i = 0, req_areg_i = 0;
  logic [1:0]  req_size_i = 0;
  logic        req_signed_i = 0, req_sat_i = 0;
  logic [31:0] req_addr_i = 0, req_wdata_i = 0;
  logic        busy_o, mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_be_o;
  logic [63:0] mem_wdata_o;
  logic [63:0] mem_rdata_i = '0;
  logic        ld_valid_o, fault_o;
  logic [31:0] ld_data_o, fault_addr_o;

  int total = 0, bad = 0, cyc = 0;
  bit run_chk = 0, done = 0;

  always #(TCK/2) clk_i = ~clk_i;

  lsu_align i_lsu_align (.*);

  // memory served to the design, and the reference view of it
  bit [7:0] dmem [bit [31:0]];
  bit [7:0] rmem [bit [31:0]];
  function automatic bit [7:0] pat(bit [31:0] a); return a[7:0] ^ 8'h5A; endfunction
  function automatic bit [7:0] drd(bit [31:0] a); return dmem.exists(a) ? dmem[a] : pat(a); endfunction
  function automatic bit [7:0] rrd(bit [31:0] a); return rmem.exists(a) ? rmem[a] : pat(a); endfunction

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (mem_req_o) begin
      if (mem_we_o) begin
        for (int i = 0; i < 8; i++) if (mem_be_o[i]) dmem[mem_addr_o + i] = mem_wdata_o[8*i +: 8];
      end else begin
        for (int i = 0; i < 8; i++) mem_rdata_i[8*i +: 8] <= drd(mem_addr_o + i);
      end
    end
  end

  bit [31:0] exp_ld [int];
  bit [31:0] exp_flt [int];
  bit        exp_busy [int];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  always @(negedge clk_i) if (run_chk) begin
    chk(ld_valid_o == exp_ld.exists(cyc), "R1 ld_valid", ld_valid_o, exp_ld.exists(cyc));
    if (ld_valid_o && exp_ld.exists(cyc))
      chk(ld_data_o == exp_ld[cyc], "R1/R2/R4/R7 ld_data", ld_data_o, exp_ld[cyc]);
    chk(fault_o == exp_flt.exists(cyc), "R5 fault", fault_o, exp_flt.exists(cyc));
    if (fault_o && exp_flt.exists(cyc))
      chk(fault_addr_o == exp_flt[cyc], "R5 fault_addr", fault_addr_o, exp_flt[cyc]);
    chk(busy_o == exp_busy.exists(cyc), "R7 busy", busy_o, exp_busy.exists(cyc));
  end

  function automatic bit [31:0] sat_ref(bit [31:0] d, int nb, bit sgn);
    longint x, hi, lo;
    if (nb == 4) return d;
    x  = sgn ? longint'($signed(d)) : longint'(d);
    hi = sgn ? (64'sd1 <<< (8*nb-1)) - 1 : (64'sd1 <<< (8*nb)) - 1;
    lo = sgn ? -(64'sd1 <<< (8*nb-1)) : 0;
    if (x > hi) x = hi;
    if (x < lo) x = lo;
    return x[31:0];
  endfunction

  task automatic op(bit st, bit areg, bit [1:0] sz, bit sgn, bit sat, bit [31:0] a, bit [31:0] d);
    int nb, o;
    bit flt, spl;
    bit [31:0] v, sv;
    bit [7:0] be0, be1;
    @(negedge clk_i);
    req_valid_i = 1; req_store_i = st; req_areg_i = areg; req_size_i = sz;
    req_signed_i = sgn; req_sat_i = sat; req_addr_i = a; req_wdata_i = d;
    nb  = areg ? 4 : (sz == 0 ? 1 : (sz == 1 ? 2 : 4));
    flt = areg ? (a[1:0] != 0) : (nb > 1 && a[0]);
    o   = a % 8;
    spl = !flt && (o + nb > 8);
    be0 = 0; be1 = 0;
    for (int i = 0; i < nb; i++) if (o + i < 8) be0[o+i] = 1; else be1[o+i-8] = 1;
    #1;
    chk(mem_req_o == !flt, "R3/R4/R5 mem_req", mem_req_o, !flt);
    if (flt) exp_flt[cyc+1] = a;
    else begin
      chk(mem_addr_o == (a & ~32'h7), "R1 beat addr", mem_addr_o, a & ~32'h7);
      if (st) begin
        sv = sat ? sat_ref(d, nb, sgn) : d;
        chk(mem_we_o && mem_be_o == be0, "R6 be beat0", mem_be_o, be0);
        for (int i = 0; i < nb; i++) if (o + i < 8)
          chk(mem_wdata_o[8*(o+i) +: 8] == sv[8*i +: 8], "R6/R8 lane data", mem_wdata_o[8*(o+i) +: 8], sv[8*i +: 8]);
        for (int i = 0; i < nb; i++) rmem[a+i] = sv[8*i +: 8];
      end else begin
        v = 0;
        for (int i = 0; i < nb; i++) v |= 32'(rrd(a+i)) << (8*i);
        if (nb < 4 && sgn && !areg && v[8*nb-1]) v |= ~((32'd1 << (8*nb)) - 1);
        exp_ld[cyc + (spl ? 2 : 1)] = v;
      end
    end
    if (spl) begin
      exp_busy[cyc+1] = 1;
      @(negedge clk_i);
      req_valid_i = 0;
      #1;
      chk(mem_req_o && mem_addr_o == (a & ~32'h7) + 8, "R7 second beat", mem_addr_o, (a & ~32'h7) + 8);
      if (st) begin
        chk(mem_be_o == be1, "R7 be beat1", mem_be_o, be1);
        for (int i = 0; i < nb; i++) if (o + i >= 8)
          chk(mem_wdata_o[8*(o+i-8) +: 8] == sv[8*i +: 8], "R7 lane data beat1",
              mem_wdata_o[8*(o+i-8) +: 8], sv[8*i +: 8]);
      end
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin @(negedge clk_i); req_valid_i = 0; end
  endtask

  initial begin
    #(TCK * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(!busy_o && !ld_valid_o && !fault_o && !mem_req_o, "R9 reset outputs",
        {busy_o, ld_valid_o, fault_o, mem_req_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    run_chk = 1;

    // R6 word store, then byte/half loads (R1, R2)
    op(1, 0, 2, 0, 0, 32'h100, 32'h8899_AABB);
    for (int b = 0; b < 4; b++) op(0, 0, 0, 1, 0, 32'h100 + b, 0);
    for (int b = 0; b < 4; b++) op(0, 0, 0, 0, 0, 32'h100 + b, 0);
    op(0, 0, 1, 1, 0, 32'h102, 0);
    op(0, 0, 1, 0, 0, 32'h102, 0);
    // R3 sweep over all lane offsets and sizes for data registers (R7 at offset 6)
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 8; o++) op(0, 0, 2'(sz), 1, 0, 32'h140 + o, 0);
    // R7 split store and split load back
    op(1, 0, 2, 0, 0, 32'h10E, 32'hCAFE_F00D);
    op(0, 0, 2, 0, 0, 32'h10E, 0);
    op(1, 0, 3, 0, 0, 32'h116, 32'h1234_5678);
    op(0, 0, 2, 1, 0, 32'h116, 0);
    // R4 address-register class, size input ignored, no extension
    op(1, 1, 0, 1, 0, 32'h200, 32'hF00F_8001);
    op(0, 1, 0, 1, 0, 32'h200, 0);
    op(0, 1, 1, 1, 0, 32'h204, 0);
    for (int o = 1; o < 4; o++) op(0, 1, 2, 0, 0, 32'h200 + o, 0);
    op(1, 1, 2, 0, 0, 32'h206, 32'h1);
    op(0, 0, 1, 0, 0, 32'h201, 0);
    op(1, 0, 2, 0, 0, 32'h203, 32'h5);
    // R8 saturating stores
    op(1, 0, 0, 1, 1, 32'h300, 32'd300);
    op(1, 0, 0, 1, 1, 32'h301, -32'sd1000);
    op(1, 0, 0, 0, 1, 32'h302, 32'hFFFF_FFFF);
    op(1, 0, 0, 1, 1, 32'h303, 32'h0000_0042);
    op(1, 0, 1, 1, 1, 32'h304, 32'd40000);
    op(1, 0, 1, 1, 1, 32'h306, -32'sd40000);
    op(1, 0, 1, 0, 1, 32'h308, 32'h0001_2345);
    op(1, 0, 1, 0, 1, 32'h30A, 32'h0000_1234);
    op(1, 0, 0, 0, 0, 32'h30C, 32'h0000_01FF);
    op(1, 0, 2, 1, 1, 32'h310, 32'h8000_0000);
    op(0, 0, 2, 0, 0, 32'h300, 0);
    op(0, 0, 2, 0, 0, 32'h304, 0);
    op(0, 0, 2, 0, 0, 32'h308, 0);
    op(0, 0, 2, 0, 0, 32'h30C, 0);
    op(0, 0, 2, 0, 0, 32'h310, 0);
    // load return coinciding with a suppressed misaligned request (R5)
    op(0, 0, 0, 1, 0, 32'h101, 0);
    op(0, 0, 2, 0, 0, 32'h105, 0);
    op(0, 0, 2, 0, 0, 32'h10E, 0);
    op(0, 1, 2, 0, 0, 32'h10A, 0);
    op(0, 0, 1, 1, 0, 32'h100, 0);
    op(0, 0, 1, 0, 0, 32'h177, 0);
    idle(4);
    run_chk = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule